// File: doc/BRIEF.md
# Shift-Register Row Select Encoder

Some LED matrix panels drive their rows from serial shift registers instead of from a binary decoder on five address lines. This block lets a scan controller built for binary addressing drive such panels anyway. For each row advance it receives a row number and a strobe. It then drives a shift clock and a shift data line so that a single active token moves through an external eight-stage row register. It keeps a blanking line low, and it drives the upper row-address bits onto two enable lines. The row that ends up active is the same row that a plain five-bit address would select.

When rows arrive in order, each advance costs one shift pulse. A new token enters on every row whose low three bits are zero. If the requested row is not the one after the last accepted row, the block clears the external register with a run of zero shifts. It then rebuilds the token at the requested position. The first advance after reset always takes this recovery path, because the contents of the external register are unknown at that point. Each shift bit takes three system clocks: data setup, clock high, clock low with data held.

Top module: `rsel_enc`

## Requirements
- R1: An accepted in-sequence advance produces exactly one shift-clock pulse, and that pulse is high for one system clock. In sequence means the requested row equals the previous accepted row plus one, modulo 2^ROW_W, so row 31 followed by row 0 is in sequence.
- R2: The data line takes its new value one system clock before the shift clock rises. It keeps that value while the clock is high and at the clock edge where the shift clock falls.
- R3: On an in-sequence advance, the shifted bit is 1 exactly when bits [2:0] of the requested row are zero. An external eight-bit register that shifts on the rising shift clock, with the new bit entering at position 0, then holds a single 1 at position row[2:0].
- R4: The blanking output is held at 0 at all times.
- R5: row_en[0] carries bit 3 of the accepted row and row_en[1] carries bit 4. Both update on the clock after acceptance and are held until the next accepted advance.
- R6: An accepted out-of-sequence advance shifts eight zeros, then a one, then row[2:0] zeros, for 9+row[2:0] pulses in all. The external register then holds a single 1 at position row[2:0].
- R7: The first advance after reset follows the R6 sequence whatever row it requests.
- R8: An advance strobe that arrives while a shift sequence is in progress is ignored. It produces no shift pulse, leaves row_en unchanged and does not change the expected next row. A sequence is in progress from acceptance until the shifter is idle again, which is one clock after the last falling shift clock.
- R9: During reset, the shift clock, the shift data line and row_en are all driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Row-advance strobe from the scan controller |
| row_addr | input | ROW_W (5) | Row requested with the strobe |
| row_clk | output | 1 | Shift clock to the panel row registers, active on its rising edge |
| row_data | output | 1 | Serial token data to the panel row registers |
| row_blank | output | 1 | Blanking line, held low |
| row_en | output | ROW_W-GRP_W (2) | Upper row-address bits driven onto the panel enable lines |

## Verification
The bench builds the block with its default parameters: five row bits in groups of eight. With these values a full frame of 32 rows, including the wrap from row 31 to row 0, takes only a few hundred cycles. The same run covers every group boundary where a new token enters. A model of the external eight-stage register starts from a garbage pattern, which shows that the flush of the recovery sequence really clears it. The run also covers forward jumps, backward jumps, a repeated row, a strobe that arrives while a sequence is in progress, and a reset in the middle of the run.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

    // Width of the shift-bit counters; covers GROUP + GROUP bits comfortably.
    parameter int unsigned CNT_W = 8;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SETUP,
        TX_HIGH,
        TX_HOLD
    } tx_state_e;

    // One shift job: how many bits in total, how many belong to the load
    // phase (the rest are flush zeros sent first), and the value of the
    // first load bit.
    typedef struct packed {
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] load;
        logic             first_one;
    } job_t;

endpackage

// File: rtl/rsel_plan.sv
module rsel_plan
    import rsel_pkg::*;
#(
    parameter int unsigned ROW_W = 5,
    parameter int unsigned GRP_W = 3
) (
    input  logic [ROW_W-1:0] row,
    input  logic [ROW_W-1:0] cur,
    input  logic             synced,
    output job_t             job
);
    localparam int unsigned GROUP = 1 << GRP_W;

    logic             in_seq;
    logic [GRP_W-1:0] low;

    assign low    = row[GRP_W-1:0];
    assign in_seq = synced && (row == ROW_W'(cur + 1'b1));

    always_comb begin
        if (in_seq) begin
            job.total     = CNT_W'(1);
            job.load      = CNT_W'(1);
            job.first_one = (low == '0);
        end else begin
            job.total     = CNT_W'(GROUP) + CNT_W'(low) + CNT_W'(1);
            job.load      = CNT_W'(low) + CNT_W'(1);
            job.first_one = 1'b1;
        end
    end

endmodule

// File: rtl/rsel_tx.sv
module rsel_tx
    import rsel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic din,
    output logic ready,
    output logic idle,
    output logic sclk,
    output logic sdata
);
    tx_state_e state;
    logic      d_q;

    assign ready = (state == TX_IDLE) || (state == TX_HOLD);
    assign idle  = (state == TX_IDLE);
    assign sclk  = (state == TX_HIGH);
    assign sdata = (state != TX_IDLE) ? d_q : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            d_q   <= 1'b0;
        end else begin
            case (state)
                TX_SETUP: state <= TX_HIGH;
                TX_HIGH:  state <= TX_HOLD;
                default: begin
                    if (start) begin
                        state <= TX_SETUP;
                        d_q   <= din;
                    end else begin
                        state <= TX_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/rsel_enc.sv
module rsel_enc
    import rsel_pkg::*;
#(
    parameter int unsigned ROW_W = 5,
    parameter int unsigned GROUP = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                adv,
    input  logic [ROW_W-1:0]                    row_addr,
    output logic                                row_clk,
    output logic                                row_data,
    output logic                                row_blank,
    output logic [ROW_W-$clog2(GROUP)-1:0]      row_en
);
    localparam int unsigned GRP_W = $clog2(GROUP);
    localparam int unsigned HI_W  = ROW_W - GRP_W;

    logic [ROW_W-1:0] cur_row;
    logic             synced;
    logic [HI_W-1:0]  en_q;
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] load_q;
    logic             first_q;

    job_t job;
    logic tx_ready, tx_idle;
    logic busy, accept, start, bit_d;

    rsel_plan #(.ROW_W(ROW_W), .GRP_W(GRP_W)) u_plan (
        .row    (row_addr),
        .cur    (cur_row),
        .synced (synced),
        .job    (job)
    );

    assign busy   = (rem != '0) || !tx_idle;
    assign accept = adv && !busy;
    assign start  = (rem != '0) && tx_ready;
    // The first load bit is sent when the remaining count equals the load size.
    assign bit_d  = first_q && (rem == load_q);

    rsel_tx u_tx (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .din   (bit_d),
        .ready (tx_ready),
        .idle  (tx_idle),
        .sclk  (row_clk),
        .sdata (row_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_row <= '0;
            synced  <= 1'b0;
            en_q    <= '0;
            rem     <= '0;
            load_q  <= '0;
            first_q <= 1'b0;
        end else if (accept) begin
            cur_row <= row_addr;
            synced  <= 1'b1;
            en_q    <= row_addr[ROW_W-1:GRP_W];
            rem     <= job.total;
            load_q  <= job.load;
            first_q <= job.first_one;
        end else if (start) begin
            rem     <= rem - 1'b1;
        end
    end

    assign row_en    = en_q;
    assign row_blank = 1'b0;

endmodule

// File: rtl/rsel_enc_chk.sv
module rsel_enc_chk #(
    parameter int unsigned ROW_W = 5,
    parameter int unsigned GRP_W = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   adv,
    input logic [ROW_W-1:0]       row_addr,
    input logic                   sclk,
    input logic                   sdata,
    input logic                   blank,
    input logic [ROW_W-GRP_W-1:0] row_en,
    input logic                   accept,
    input logic                   busy
);
    // R1
    one_cycle_high_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |=> !sclk);

    // R2
    data_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(sdata));

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> $stable(sdata));

    // R4
    blank_low_chk: assert property (@(posedge clk) disable iff (rst)
        blank == 1'b0);

    // R5
    en_follow_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> row_en == $past(row_addr[ROW_W-1:GRP_W]));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && busy) |=> $stable(row_en));

    // R9
    reset_low_chk: assert property (@(posedge clk)
        rst |=> (!sclk && !sdata && row_en == '0));

endmodule

bind rsel_enc rsel_enc_chk #(.ROW_W(ROW_W), .GRP_W(GRP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .row_addr (row_addr),
    .sclk     (row_clk),
    .sdata    (row_data),
    .blank    (row_blank),
    .row_en   (row_en),
    .accept   (accept),
    .busy     (busy)
);

// File: tb/rsel_enc_tb.sv
module rsel_enc_tb;
    localparam int ROW_W = 5;
    localparam int GROUP = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             adv;
    logic [ROW_W-1:0] row_addr;
    logic             row_clk, row_data, row_blank;
    logic [1:0]       row_en;

    int errors = 0;
    int checks = 0;
    int pulse_cnt = 0;
    logic [GROUP-1:0] ext_sr = 8'hA5;

    typedef struct {
        string      req;
        int         pulses;
        logic [7:0] sr;
        logic [1:0] en;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    rsel_enc #(.ROW_W(ROW_W), .GROUP(GROUP)) u_dut (
        .clk(clk), .rst(rst), .adv(adv), .row_addr(row_addr),
        .row_clk(row_clk), .row_data(row_data), .row_blank(row_blank),
        .row_en(row_en)
    );

    // Model of the external eight-stage row register on the panel.
    always @(posedge row_clk) begin
        ext_sr    <= {ext_sr[GROUP-2:0], row_data};
        pulse_cnt <= pulse_cnt + 1;
    end

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: issue one advance, wait for its shifts, push the expected result.
    task automatic step(input int row, input int pulses, input string req);
        exp_t e;
        @(negedge clk);
        row_addr = ROW_W'(row);
        adv = 1'b1;
        @(negedge clk);
        adv = 1'b0;
        repeat (3 * pulses + 3) @(negedge clk);
        e.req = req;
        e.pulses = pulses;
        e.sr = 8'(1 << (row % 8));
        e.en = 2'(row >> 3);
        exp_q.push_back(e);
    endtask

    // Monitor: pop expected items and compare with the panel-side model.
    int last_cnt = 0;
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            chk(e.req, "pulses", pulse_cnt - last_cnt, e.pulses);
            chk(e.req, "ext_reg", int'(ext_sr), int'(e.sr));
            chk("R5", "row_en", int'(row_en), int'(e.en));
            chk("R4", "blank", int'(row_blank), 0);
            last_cnt = pulse_cnt;
        end
    end

    task automatic reset_check();
        chk("R9", "row_clk", int'(row_clk), 0);
        chk("R9", "row_data", int'(row_data), 0);
        chk("R9", "row_en", int'(row_en), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        adv = 1'b0;
        row_addr = '0;
        repeat (3) @(negedge clk);
        reset_check();
        rst = 1'b0;

        // R7: first advance after reset takes the recovery path (9 pulses).
        step(0, 9, "R7");
        // R1 R3: in-sequence frame, one pulse per row, token at row[2:0].
        for (int r = 1; r < 32; r++) step(r, 1, "R3");
        step(0, 1, "R1");          // wrap 31 -> 0
        step(13, 14, "R6");        // forward jump: 8 + 1 + 5
        step(14, 1, "R1");

        // R8: second strobe while busy is ignored.
        @(negedge clk);
        row_addr = 5'd15;
        adv = 1'b1;
        @(negedge clk);
        row_addr = 5'd20;
        @(negedge clk);
        adv = 1'b0;
        repeat (8) @(negedge clk);
        begin
            exp_t e;
            e.req = "R8"; e.pulses = 1; e.sr = 8'h80; e.en = 2'd1;
            exp_q.push_back(e);
        end
        step(16, 1, "R8");         // 16 still counts as next after 15
        step(16, 9, "R6");         // repeated row is out of sequence
        step(5, 14, "R6");         // backward jump

        // Mid-run reset, then a row that would be in sequence from 0.
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        reset_check();
        rst = 1'b0;
        step(1, 10, "R7");
        step(2, 1, "R1");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule